// File: doc/BRIEF.md
# Word-Capable DMA Channel

This block is a single channel of a DMA engine. It moves one 8-bit or 16-bit value per clock cycle between a memory port and an I/O port. It can also run a check pass that reads the I/O side and drops the data. A 24-bit current address and a 16-bit current count each keep a base copy. An 8-bit mode register selects the beat width, the direction, reload on completion and single-beat operation. Arbitration between channels and the host register decode sit outside the block. The channel is programmed through a direct write port that picks one register per write.

A request pulse, from hardware or from software, arms the channel. While armed and unmasked, the channel performs one beat per cycle. The memory and I/O strobes are combinational in the beat cycle, and the read data is taken in the same cycle. The run ends when a beat finds the count already at zero. At that point the channel either reloads from its base copies or masks itself. It also raises a one-cycle completion pulse and a sticky completion flag, and drops any armed request.

Top module: `dmach_top`

## Requirements
- R1: Mode bit 0 set makes each beat 16 bits wide. Clear makes it 8 bits wide, with data carried on bits 7:0 and bits 15:8 forced to zero. `word_mode` always equals mode bit 0.
- R2: Mode bits 3:2 select the direction. 00 raises `io_rd` only (check pass). 01 raises `io_rd` and `mem_wr`, with `mem_wdata` taken from `io_rdata`. 10 raises `mem_rd` and `io_wr`, with `io_wdata` taken from `mem_rdata`. 11 raises no strobe but still counts the beat.
- R3: Each beat advances `mem_addr` by 2 in 16-bit mode and by 1 in 8-bit mode, wrapping modulo 2^24.
- R4: `tmp_q` holds the last value moved by a direction-01 or direction-10 beat. Check-pass beats and direction-11 beats leave it unchanged.
- R5: A beat that finds the count at zero is the completion beat, so count+1 beats run. `tc_pulse` is high for exactly the cycle after that beat. `tc_flag` stays set until reset or a count write.
- R6: On completion with mode bit 4 set, the address and count reload from their base copies and the mask is unchanged. With mode bit 4 clear, the channel masks itself and the count wraps to all ones.
- R7: Completion clears the armed request, so a multi-beat run stops after its completion beat.
- R8: With mode bits 7:6 = 01, each request yields exactly one beat. Any other value keeps the channel running every cycle from one request until completion.
- R9: `busy` is 0 while `dis_all` is high or the current count is zero, and 1 otherwise.
- R10: Reset leaves the channel masked with every register zero. A beat happens only in a cycle where a request is armed and the channel is unmasked. A request pulse arms the channel from the next cycle on, and a request made while masked stays armed.
- R11: A write with `cfg_sel` 0 loads both address copies from `cfg_wdata[23:0]`. `cfg_sel` 1 loads both count copies from `cfg_wdata[15:0]` and clears `tc_flag`. `cfg_sel` 2 loads the mode from `cfg_wdata[7:0]`. `cfg_sel` 3 loads the mask from `cfg_wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode, 3 mask |
| cfg_wdata | input | 24 | Register write data |
| dis_all | input | 1 | Global disable, forces busy low |
| hreq | input | 1 | Hardware request pulse |
| sreq | input | 1 | Software request pulse |
| mem_addr | output | 24 | Current transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, same cycle |
| tmp_q | output | 16 | Last moved value |
| tc_pulse | output | 1 | One-cycle completion pulse |
| tc_flag | output | 1 | Sticky completion flag |
| chan_masked | output | 1 | Channel mask state |
| busy | output | 1 | Count nonzero and not globally disabled |
| word_mode | output | 1 | 16-bit beat mode |

## Verification
The properties on address stepping, self-masking, single-beat release and end-of-run release assume that no register write lands in the same cycle as a beat. The stepping and self-masking properties exclude any such cycle explicitly. The release properties assume that no fresh request pulse arrives in the cycle of the beat they watch. The stimulus issues register writes only while the channel is masked or has no armed request. It spaces request pulses at least two cycles apart in single-beat mode, and sends no request while a multi-beat run is still in progress.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    DIR_VERIFY = 2'b00,
    DIR_IO2MEM = 2'b01,
    DIR_MEM2IO = 2'b10,
    DIR_NONE   = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_MASK  = 2'd3
  } sel_e;

  // bits 7:6 service style, 5 spare, 4 reload, 3:2 direction, 1 spare, 0 width
  typedef struct packed {
    logic [1:0] xstyle;
    logic       spare5;
    logic       reload;
    dir_e       dir;
    logic       spare1;
    logic       wide;
  } mode_t;

  localparam logic [1:0] STYLE_SINGLE = 2'b01;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          beat,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output mode_t         mode_q,
  output logic          mask_q,
  output logic          tc_now,
  output logic          tc_pulse,
  output logic          tc_flag
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;
  logic [AW-1:0] step;

  assign tc_now = beat && (cur_cnt == '0);
  assign step   = mode_q.wide ? STEP_W : STEP_B;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      base_addr <= '0;
      cur_cnt   <= '0;
      base_cnt  <= '0;
      mode_q    <= '0;
      mask_q    <= 1'b1;
      tc_pulse  <= 1'b0;
      tc_flag   <= 1'b0;
    end else begin
      tc_pulse <= tc_now;
      if (beat) begin
        cur_addr <= cur_addr + step;
        cur_cnt  <= cur_cnt - CW'(1);
        if (tc_now) begin
          tc_flag <= 1'b1;
          if (mode_q.reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
          end else begin
            mask_q <= 1'b1;
          end
        end
      end
      if (cfg_we) begin
        case (sel_e'(cfg_sel))
          SEL_ADDR: begin
            cur_addr  <= cfg_wdata;
            base_addr <= cfg_wdata;
          end
          SEL_COUNT: begin
            cur_cnt  <= cfg_wdata[CW-1:0];
            base_cnt <= cfg_wdata[CW-1:0];
            tc_flag  <= 1'b0;
          end
          SEL_MODE: mode_q <= mode_t'(cfg_wdata[7:0]);
          default:  mask_q <= cfg_wdata[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
  import dmach_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hreq,
  input  logic          sreq,
  input  logic          mask_q,
  input  logic          tc_now,
  input  mode_t         mode_q,
  input  logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          beat,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] io_wdata,
  output logic [DW-1:0] tmp_q
);
  localparam int BW = DW / 2;

  logic pend_q;
  logic single;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic w);
    return w ? d : {{(DW-BW){1'b0}}, d[BW-1:0]};
  endfunction

  assign beat   = pend_q && !mask_q;
  assign single = (mode_q.xstyle == STYLE_SINGLE);

  always_comb begin
    io_rd     = beat && (mode_q.dir == DIR_VERIFY || mode_q.dir == DIR_IO2MEM);
    mem_wr    = beat && (mode_q.dir == DIR_IO2MEM);
    mem_rd    = beat && (mode_q.dir == DIR_MEM2IO);
    io_wr     = beat && (mode_q.dir == DIR_MEM2IO);
    mem_wdata = fit(io_rdata, mode_q.wide);
    io_wdata  = fit(mem_rdata, mode_q.wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tmp_q  <= '0;
    end else begin
      if (beat && (tc_now || single)) pend_q <= 1'b0;
      if (hreq || sreq) pend_q <= 1'b1;
      if (mem_wr)     tmp_q <= mem_wdata;
      else if (io_wr) tmp_q <= io_wdata;
    end
  end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dis_all,
  input  logic          hreq,
  input  logic          sreq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  output logic [DW-1:0] tmp_q,
  output logic          tc_pulse,
  output logic          tc_flag,
  output logic          chan_masked,
  output logic          busy,
  output logic          word_mode
);
  logic [CW-1:0] cur_cnt;
  mode_t         mode_q;
  logic          beat;
  logic          tc_now;

  dmach_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .beat(beat), .cur_addr(mem_addr), .cur_cnt(cur_cnt), .mode_q(mode_q),
    .mask_q(chan_masked), .tc_now(tc_now), .tc_pulse(tc_pulse), .tc_flag(tc_flag)
  );

  dmach_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst), .hreq(hreq), .sreq(sreq), .mask_q(chan_masked),
    .tc_now(tc_now), .mode_q(mode_q), .io_rdata(io_rdata), .mem_rdata(mem_rdata),
    .beat(beat), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .mem_wdata(mem_wdata), .io_wdata(io_wdata), .tmp_q(tmp_q)
  );

  assign busy      = !dis_all && (cur_cnt != '0);
  assign word_mode = mode_q.wide;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          hreq,
  input logic          sreq,
  input logic          beat,
  input logic          reload,
  input logic          single,
  input logic          word_mode,
  input logic [CW-1:0] cur_cnt,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          tc_pulse,
  input logic          chan_masked
);
  logic [AW-1:0] step_w;
  logic          at_zero;
  assign step_w  = word_mode ? AW'(2) : AW'(1);
  assign at_zero = (cur_cnt == '0);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(io_rd && io_wr)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (beat && !at_zero && !cfg_we) |=> (mem_addr == $past(mem_addr) + $past(step_w))); // R3
  AST_NO_EARLY_TC: assert property (@(posedge clk) disable iff (rst)
    (beat && !at_zero) |=> !tc_pulse); // R5
  AST_MASK_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    (beat && at_zero && !reload && !cfg_we) |=> chan_masked); // R6
  AST_RUN_STOPS: assert property (@(posedge clk) disable iff (rst)
    (beat && at_zero && !hreq && !sreq) |=> !beat); // R7
  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (beat && single && !hreq && !sreq) |=> !beat); // R8
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    chan_masked |-> !(mem_rd || mem_wr || io_rd || io_wr)); // R10
endmodule

bind dmach_top dmach_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .hreq(hreq), .sreq(sreq), .beat(beat),
  .reload(mode_q.reload), .single(mode_q.xstyle == 2'b01), .word_mode(word_mode),
  .cur_cnt(cur_cnt), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .tc_pulse(tc_pulse), .chan_masked(chan_masked)
);

// File: tb/tb_dmach_top.sv
`timescale 1ns/1ps
module tb_dmach_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [23:0] cfg_wdata = 0;
  logic        dis_all = 0, hreq = 0, sreq = 0;
  logic [15:0] mem_rdata = 16'h1234, io_rdata = 16'hBEEF;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic [15:0] mem_wdata, io_wdata, tmp_q;
  logic        tc_pulse, tc_flag, chan_masked, busy, word_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dmach_top dut (.*);

  // behavioural reference state
  int m_addr, m_baddr, m_cnt, m_bcnt, m_mode, m_mask, m_pend, m_tmp, m_tcp, m_tcf;

  function automatic int fitv(int d, int w);
    return w ? (d & 32'hFFFF) : (d & 32'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_baddr = 0; m_cnt = 0; m_bcnt = 0; m_mode = 0;
      m_mask = 1; m_pend = 0; m_tmp = 0; m_tcp = 0; m_tcf = 0;
    end else begin
      int dir, wd, bt, tc;
      dir = (m_mode >> 2) & 3; wd = m_mode & 1;
      bt = m_pend && !m_mask;
      tc = bt && (m_cnt == 0);
      if (bt) begin
        if (dir == 1) m_tmp = fitv(io_rdata, wd);
        if (dir == 2) m_tmp = fitv(mem_rdata, wd);
        m_addr = (m_addr + (wd ? 2 : 1)) & 32'hFFFFFF;
        m_cnt  = (m_cnt - 1) & 32'hFFFF;
        if (tc) begin
          m_tcf = 1;
          if (m_mode & 32'h10) begin m_addr = m_baddr; m_cnt = m_bcnt; end
          else m_mask = 1;
        end
      end
      m_tcp = tc;
      if (bt && (tc || ((m_mode >> 6) & 3) == 1)) m_pend = 0;
      if (hreq || sreq) m_pend = 1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin m_addr = cfg_wdata; m_baddr = cfg_wdata; end
          2'd1: begin m_cnt = cfg_wdata & 32'hFFFF; m_bcnt = m_cnt; m_tcf = 0; end
          2'd2: m_mode = cfg_wdata & 32'hFF;
          default: m_mask = cfg_wdata[0];
        endcase
      end
    end
  end

  // compare every cycle away from the active edge, then update the data sources
  always @(negedge clk) begin
    if (!rst) begin
      int dir, wd, bt;
      dir = (m_mode >> 2) & 3; wd = m_mode & 1;
      bt = m_pend && !m_mask;
      chk(mem_addr == m_addr[23:0], "R3 R6 R11 address", mem_addr, m_addr);
      chk(io_rd == (bt && dir <= 1), "R2 R8 R10 io_rd", io_rd, bt && dir <= 1);
      chk(mem_wr == (bt && dir == 1), "R2 R7 mem_wr", mem_wr, bt && dir == 1);
      chk(mem_rd == (bt && dir == 2), "R2 R8 mem_rd", mem_rd, bt && dir == 2);
      chk(io_wr == (bt && dir == 2), "R2 R10 io_wr", io_wr, bt && dir == 2);
      if (mem_wr) chk(mem_wdata == fitv(io_rdata, wd), "R1 mem_wdata", mem_wdata, fitv(io_rdata, wd));
      if (io_wr)  chk(io_wdata == fitv(mem_rdata, wd), "R1 io_wdata", io_wdata, fitv(mem_rdata, wd));
      chk(tmp_q == m_tmp[15:0], "R4 tmp_q", tmp_q, m_tmp);
      chk(tc_pulse == m_tcp[0], "R5 R7 tc_pulse", tc_pulse, m_tcp);
      chk(tc_flag == m_tcf[0], "R5 R11 tc_flag", tc_flag, m_tcf);
      chk(chan_masked == m_mask[0], "R6 R10 R11 mask", chan_masked, m_mask);
      chk(busy == (!dis_all && m_cnt != 0), "R9 busy", busy, !dis_all && m_cnt != 0);
      chk(word_mode == m_mode[0], "R1 word_mode", word_mode, m_mode[0]);
    end
    io_rdata  = io_rdata + 16'h1357;
    mem_rdata = {mem_addr[7:0], ~mem_addr[15:8]};
  end

  task automatic step();
    @(posedge clk); #2;
  endtask
  task automatic wr(input logic [1:0] sel, input logic [23:0] d);
    step(); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    step(); cfg_we = 0;
  endtask
  task automatic pulse(input bit hw);
    step(); if (hw) hreq = 1; else sreq = 1;
    step(); hreq = 0; sreq = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) step();
  endtask

  initial begin
    idle(3);
    rst = 0;
    step();
    // R10: reset state at the ports
    chk(chan_masked && !busy && mem_addr == 0 && !tc_flag && tmp_q == 0, "R10 reset state",
        {chan_masked, busy, tc_flag}, 3'b100);
    // word I/O to memory, demand run of count+1 beats
    wr(0, 24'h000100); wr(1, 3); wr(2, 8'h05); wr(3, 0);
    pulse(1); idle(8);
    // byte memory to I/O, single beats with reload, address wrap
    wr(0, 24'hFFFFFE); wr(1, 2); wr(2, 8'h58); wr(3, 0);
    for (int i = 0; i < 4; i++) begin pulse(0); idle(2); end
    wr(3, 1);
    // word wrap at the top of the address space
    wr(0, 24'hFFFFFE); wr(1, 1); wr(2, 8'h05); wr(3, 0);
    pulse(1); idle(5);
    // check pass keeps tmp_q
    wr(0, 24'h000010); wr(1, 2); wr(2, 8'h01); wr(3, 0);
    pulse(0); idle(5);
    // direction 11 counts without strobes, single completion beat
    wr(1, 0); wr(2, 8'h0D); wr(3, 0);
    pulse(1); idle(4);
    // request while masked stays armed until unmasked
    wr(0, 24'h000200); wr(1, 1); wr(2, 8'h04);
    pulse(1); idle(4);
    wr(3, 0); idle(5);
    // global disable and count write clearing the flag
    wr(1, 5); idle(1);
    dis_all = 1; idle(3); dis_all = 0; idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule